// File: doc/BRIEF.md
# Memory-Mapped Half-Width Transfer Splitter

This block connects a master whose data bus is twice as wide as its slave's data bus. The default is a 32-bit master and a 16-bit slave. Each single read or write from the master becomes two narrow transfers on the slave side, always in the same order. The lower half goes first, at narrow word address `2*A`. The upper half follows at `2*A+1`.

Each narrow write cycle carries only the byte enables of its own half. A half whose enables are all zero is still issued on the slave side. Every narrow read cycle enables all of its bytes. The two read halves are registered and joined into one wide word.

The master sees a single transfer and is held off with its waitrequest until both narrow transfers have finished. The slave returns read data in the same cycle that it drops its waitrequest, which is a fixed-latency read.

Top module: `mm_width_split`

## Requirements
- R1: While reset is held and right after it is released, `m_wait` is 1 and neither `s_read` nor `s_write` is asserted.
- R2: Every accepted master access produces exactly two completed slave transfers. The first is at `s_addr = {m_addr,1'b0}` and the second at `s_addr = {m_addr,1'b1}`.
- R3: On a write, the first slave transfer carries `m_wdata[NW-1:0]` and the second carries `m_wdata[2*NW-1:NW]`.
- R4: On a write, the first transfer carries `s_be = m_be[NB-1:0]` and the second carries `s_be = m_be[2*NB-1:NB]`. A half with all-zero enables is still issued, and the slave word for that half is left unchanged.
- R5: On a read, `s_be` is all ones in both slave transfers.
- R6: On a read, `m_rdata` equals {second slave read value, first slave read value} in the cycle `m_wait` is 0.
- R7: While `s_read` or `s_write` is high and `s_wait` is high, `s_addr`, `s_read`, `s_write`, `s_wdata` and `s_be` keep their values into the next cycle.
- R8: `m_wait` drops to 0 in the cycle after the second slave transfer completes, stays 0 for exactly one cycle, and is 1 at all other times. With W slave wait cycles per transfer, a command presented at one falling edge sees `m_wait` low at the (2W+3)-th falling edge after it.
- R9: `s_read` and `s_write` are never high together, and a read access issues only reads and a write access issues only writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| m_addr | input | M_AW | Wide word address from the master |
| m_read | input | 1 | Master read request |
| m_write | input | 1 | Master write request |
| m_wdata | input | 2*NW | Master write data |
| m_be | input | NW/4 | Master byte enables, bit k enables byte k |
| m_rdata | output | 2*NW | Assembled read data |
| m_wait | output | 1 | Hold-off to the master; 0 marks completion |
| s_addr | output | M_AW+1 | Narrow word address to the slave |
| s_read | output | 1 | Slave read request |
| s_write | output | 1 | Slave write request |
| s_wdata | output | NW | Narrow write data |
| s_be | output | NW/8 | Narrow byte enables |
| s_rdata | input | NW | Narrow read data, valid when the read completes |
| s_wait | input | 1 | Slave hold-off |

## Verification
The checks assume a master that holds its command steady while `m_wait` is high and never raises read and write together. They also assume a slave whose read data is valid in the cycle it lowers `s_wait`. The bench master changes its signals only at falling edges, and only once it has seen `m_wait` low. The bench slave model counts a fixed number of wait cycles for each transfer and drives its data combinationally from its storage, so both assumptions hold for every scenario.

// File: rtl/msplit_pkg.sv
`timescale 1ns/1ps
package msplit_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LO   = 2'd1,
      ST_HI   = 2'd2,
      ST_DONE = 2'd3
   } msplit_state_e;
endpackage

// File: rtl/msplit_seq.sv
`timescale 1ns/1ps
module msplit_seq
   import msplit_pkg::*;
(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          m_read,
   input  logic          m_write,
   input  logic          s_wait,
   output msplit_state_e state,
   output logic          accept,
   output logic          lo_done,
   output logic          hi_done
);
   msplit_state_e nxt;

   assign accept  = (state == ST_IDLE) && (m_read || m_write);
   assign lo_done = (state == ST_LO) && !s_wait;
   assign hi_done = (state == ST_HI) && !s_wait;

   always_comb begin
      nxt = state;
      unique case (state)
         ST_IDLE: if (accept)  nxt = ST_LO;
         ST_LO:   if (lo_done) nxt = ST_HI;
         ST_HI:   if (hi_done) nxt = ST_DONE;
         ST_DONE:              nxt = ST_IDLE;
         default:              nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= nxt;
   end

   // R8
   done_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DONE) |=> (state == ST_IDLE));

   // R2
   lo_then_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lo_done |=> (state == ST_HI));
endmodule

// File: rtl/msplit_cmd_hold.sv
`timescale 1ns/1ps
module msplit_cmd_hold #(
   parameter int AW = 8,
   parameter int WW = 32,
   parameter int WB = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] addr,
   input  logic [WW-1:0] wdata,
   input  logic [WB-1:0] be,
   input  logic          is_rd,
   output logic [AW-1:0] q_addr,
   output logic [WW-1:0] q_wdata,
   output logic [WB-1:0] q_be,
   output logic          q_rd
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q_addr  <= '0;
         q_wdata <= '0;
         q_be    <= '0;
         q_rd    <= 1'b0;
      end else if (load) begin
         q_addr  <= addr;
         q_wdata <= wdata;
         q_be    <= be;
         q_rd    <= is_rd;
      end
   end
endmodule

// File: rtl/msplit_lane_mux.sv
`timescale 1ns/1ps
module msplit_lane_mux #(
   parameter int NW = 16
) (
   input  logic [2*NW-1:0]   wdata,
   input  logic [NW/4-1:0]   be,
   input  logic              sel_hi,
   input  logic              is_rd,
   output logic [NW-1:0]     n_wdata,
   output logic [NW/8-1:0]   n_be
);
   localparam int NB = NW / 8;

   for (genvar k = 0; k < NB; k++) begin : g_lane
      assign n_wdata[8*k +: 8] = sel_hi ? wdata[NW + 8*k +: 8] : wdata[8*k +: 8];
      assign n_be[k]           = is_rd | (sel_hi ? be[NB + k] : be[k]);
   end
endmodule

// File: rtl/msplit_rd_collect.sv
`timescale 1ns/1ps
module msplit_rd_collect #(
   parameter int NW = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cap_lo,
   input  logic            cap_hi,
   input  logic [NW-1:0]   n_rdata,
   output logic [2*NW-1:0] word
);
   logic [NW-1:0] lo_q, hi_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo_q <= '0;
         hi_q <= '0;
      end else begin
         if (cap_lo) lo_q <= n_rdata;
         if (cap_hi) hi_q <= n_rdata;
      end
   end

   assign word = {hi_q, lo_q};

   // R6
   cap_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(cap_lo && cap_hi));
endmodule

// File: rtl/mm_width_split.sv
`timescale 1ns/1ps
module mm_width_split
   import msplit_pkg::*;
#(
   parameter int M_AW = 8,
   parameter int NW   = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [M_AW-1:0]   m_addr,
   input  logic              m_read,
   input  logic              m_write,
   input  logic [2*NW-1:0]   m_wdata,
   input  logic [NW/4-1:0]   m_be,
   output logic [2*NW-1:0]   m_rdata,
   output logic              m_wait,
   output logic [M_AW:0]     s_addr,
   output logic              s_read,
   output logic              s_write,
   output logic [NW-1:0]     s_wdata,
   output logic [NW/8-1:0]   s_be,
   input  logic [NW-1:0]     s_rdata,
   input  logic              s_wait
);
   localparam int WW = 2 * NW;
   localparam int NB = NW / 8;
   localparam int WB = 2 * NB;

   if ((NW % 8) != 0 || NW < 8) begin : g_bad_nw
      $error("mm_width_split: NW must be a positive multiple of 8");
   end
   if (M_AW < 1) begin : g_bad_aw
      $error("mm_width_split: M_AW must be at least 1");
   end

   msplit_state_e  state;
   logic           accept, lo_done, hi_done;
   logic [M_AW-1:0] c_addr;
   logic [WW-1:0]  c_wdata;
   logic [WB-1:0]  c_be;
   logic           c_rd;
   logic           s_req;
   logic           sel_hi;

   msplit_seq u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .m_read  (m_read),
      .m_write (m_write),
      .s_wait  (s_wait),
      .state   (state),
      .accept  (accept),
      .lo_done (lo_done),
      .hi_done (hi_done)
   );

   msplit_cmd_hold #(.AW(M_AW), .WW(WW), .WB(WB)) u_cmd (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (accept),
      .addr    (m_addr),
      .wdata   (m_wdata),
      .be      (m_be),
      .is_rd   (m_read),
      .q_addr  (c_addr),
      .q_wdata (c_wdata),
      .q_be    (c_be),
      .q_rd    (c_rd)
   );

   assign s_req  = (state == ST_LO) || (state == ST_HI);
   assign sel_hi = (state == ST_HI);

   msplit_lane_mux #(.NW(NW)) u_mux (
      .wdata   (c_wdata),
      .be      (c_be),
      .sel_hi  (sel_hi),
      .is_rd   (c_rd),
      .n_wdata (s_wdata),
      .n_be    (s_be)
   );

   msplit_rd_collect #(.NW(NW)) u_rd (
      .clk     (clk),
      .rst_n   (rst_n),
      .cap_lo  (lo_done && c_rd),
      .cap_hi  (hi_done && c_rd),
      .n_rdata (s_rdata),
      .word    (m_rdata)
   );

   assign s_addr  = {c_addr, sel_hi};
   assign s_read  = s_req && c_rd;
   assign s_write = s_req && !c_rd;
   assign m_wait  = (state != ST_DONE);

   // R1
   reset_idle_chk: assert property (@(posedge clk)
      !rst_n |=> (m_wait && !s_read && !s_write));

   // R9
   rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(s_read && s_write));

   // R7
   hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((s_read || s_write) && s_wait) |=>
         ($stable(s_addr) && $stable(s_read) && $stable(s_write) &&
          $stable(s_wdata) && $stable(s_be)));

   // R2
   hi_follows_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((s_read || s_write) && !s_wait && !s_addr[0]) |=>
         ((s_read || s_write) && s_addr[0] && $stable(s_addr[M_AW:1])));

   // R5
   read_all_bytes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      s_read |-> (s_be == {NB{1'b1}}));

   // R8
   wait_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !m_wait |=> m_wait);

   // R8
   wait_after_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(m_wait) |-> $past((s_read || s_write) && !s_wait && s_addr[0]));
endmodule

// File: tb/sim_mm_width_split.sv
`timescale 1ns/1ps
module sim_mm_width_split;
   localparam int AW = 8;
   localparam int NW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] m_addr = '0;
   logic          m_read = 1'b0, m_write = 1'b0;
   logic [31:0]   m_wdata = '0;
   logic [3:0]    m_be = '0;
   logic [31:0]   m_rdata;
   logic          m_wait;
   logic [AW:0]   s_addr;
   logic          s_read, s_write;
   logic [15:0]   s_wdata;
   logic [1:0]    s_be;
   logic [15:0]   s_rdata;
   logic          s_wait;

   int nchk = 0, nerr = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   mm_width_split #(.M_AW(AW), .NW(NW)) u0 (
      .clk(clk), .rst_n(rst_n),
      .m_addr(m_addr), .m_read(m_read), .m_write(m_write),
      .m_wdata(m_wdata), .m_be(m_be), .m_rdata(m_rdata), .m_wait(m_wait),
      .s_addr(s_addr), .s_read(s_read), .s_write(s_write),
      .s_wdata(s_wdata), .s_be(s_be), .s_rdata(s_rdata), .s_wait(s_wait)
   );

   // ---------------- slave model ----------------
   logic [15:0] mem [512];
   int          wait_n = 0;
   int          wcnt = 0;
   int          log_n = 0;
   logic [AW:0] lg_addr [64];
   logic [1:0]  lg_be   [64];
   logic [15:0] lg_wd   [64];
   logic        lg_rd   [64];
   logic        lg_wr   [64];

   function automatic logic [15:0] iv(int k);
      return 16'(k * 37) ^ 16'h3C00;
   endfunction

   assign s_wait  = (s_read || s_write) && (wcnt < wait_n);
   assign s_rdata = mem[s_addr];

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < 512; k++) mem[k] <= iv(k);
         wcnt <= 0;
      end else if (s_read || s_write) begin
         if (s_wait) wcnt <= wcnt + 1;
         else begin
            wcnt <= 0;
            lg_addr[log_n % 64] <= s_addr;
            lg_be[log_n % 64]   <= s_be;
            lg_wd[log_n % 64]   <= s_wdata;
            lg_rd[log_n % 64]   <= s_read;
            lg_wr[log_n % 64]   <= s_write;
            log_n <= log_n + 1;
            if (s_write) begin
               if (s_be[0]) mem[s_addr][7:0]  <= s_wdata[7:0];
               if (s_be[1]) mem[s_addr][15:8] <= s_wdata[15:8];
            end
         end
      end
   end

   // ---------------- helpers ----------------
   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic xfer(input bit wr, input logic [AW-1:0] a, input logic [31:0] d,
                       input logic [3:0] be, output logic [31:0] rd, output int cyc,
                       output int base);
      @(negedge clk);
      base    = log_n;
      m_addr  = a;
      m_write = wr;
      m_read  = !wr;
      m_wdata = d;
      m_be    = wr ? be : 4'hF;
      cyc     = 0;
      do begin
         @(negedge clk);
         cyc++;
      end while (m_wait && cyc < 100);
      rd      = m_rdata;
      m_read  = 1'b0;
      m_write = 1'b0;
      @(negedge clk);
      chk("R8 m_wait high again after one low cycle", 32'(m_wait), 32'd1);
   endtask

   // check the two logged slave transfers of one access
   task automatic chk_pair(input string tag, input int base, input logic [AW-1:0] a,
                           input bit wr, input logic [1:0] be_lo, input logic [1:0] be_hi);
      chk({"R2 transfer count ", tag}, 32'(log_n - base), 32'd2);
      chk({"R2 first address ", tag}, 32'(lg_addr[base % 64]), 32'({a, 1'b0}));
      chk({"R2 second address ", tag}, 32'(lg_addr[(base + 1) % 64]), 32'({a, 1'b1}));
      chk({"R9 direction first ", tag}, {30'd0, lg_rd[base % 64], lg_wr[base % 64]},
          wr ? 32'd1 : 32'd2);
      chk({"R9 direction second ", tag}, {30'd0, lg_rd[(base + 1) % 64], lg_wr[(base + 1) % 64]},
          wr ? 32'd1 : 32'd2);
      chk({"R4/R5 be first ", tag}, 32'(lg_be[base % 64]), 32'(be_lo));
      chk({"R4/R5 be second ", tag}, 32'(lg_be[(base + 1) % 64]), 32'(be_hi));
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1 m_wait in reset", 32'(m_wait), 32'd1);
      chk("R1 no slave request in reset", {30'd0, s_read, s_write}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 idle after reset", {29'd0, m_wait, s_read, s_write}, 32'd4);
   endtask

   task automatic t_write_full;
      logic [31:0] rd; int cyc, base;
      wait_n = 0;
      xfer(1'b1, 8'd5, 32'hCAFE_F00D, 4'hF, rd, cyc, base);
      chk("R8 latency zero wait", 32'(cyc), 32'd3);
      chk_pair("full write", base, 8'd5, 1'b1, 2'b11, 2'b11);
      chk("R3 low half data", 32'(lg_wd[base % 64]), 32'h0000_F00D);
      chk("R3 high half data", 32'(lg_wd[(base + 1) % 64]), 32'h0000_CAFE);
   endtask

   task automatic t_read_back;
      logic [31:0] rd; int cyc, base;
      wait_n = 2;
      xfer(1'b0, 8'd5, 32'h0, 4'hF, rd, cyc, base);
      chk("R8 latency two waits", 32'(cyc), 32'd7);
      chk("R6 read assembly", rd, 32'hCAFE_F00D);
      chk_pair("read", base, 8'd5, 1'b0, 2'b11, 2'b11);
   endtask

   task automatic t_partial_lo;
      logic [31:0] rd; int cyc, base;
      wait_n = 1;
      xfer(1'b1, 8'd5, 32'h1234_5678, 4'b0011, rd, cyc, base);
      chk("R8 latency one wait", 32'(cyc), 32'd5);
      chk_pair("low-only write", base, 8'd5, 1'b1, 2'b11, 2'b00);
      xfer(1'b0, 8'd5, 32'h0, 4'hF, rd, cyc, base);
      chk("R4 high half untouched", rd, 32'hCAFE_5678);
   endtask

   task automatic t_partial_hi;
      logic [31:0] rd; int cyc, base;
      wait_n = 0;
      xfer(1'b1, 8'd9, 32'hAAAA_BBBB, 4'b1100, rd, cyc, base);
      chk_pair("high-only write", base, 8'd9, 1'b1, 2'b00, 2'b11);
      xfer(1'b0, 8'd9, 32'h0, 4'hF, rd, cyc, base);
      chk("R4 low half untouched", rd, {16'hAAAA, iv(18)});
   endtask

   task automatic t_byte_mix;
      logic [31:0] rd; int cyc, base;
      wait_n = 0;
      xfer(1'b1, 8'd77, 32'h1122_3344, 4'b1001, rd, cyc, base);
      chk_pair("odd bytes write", base, 8'd77, 1'b1, 2'b01, 2'b10);
      xfer(1'b0, 8'd77, 32'h0, 4'hF, rd, cyc, base);
      chk("R4 per-byte merge", rd,
          {8'h11, iv(155)[7:0], iv(154)[15:8], 8'h44});
   endtask

   task automatic t_read_untouched;
      logic [31:0] rd; int cyc, base;
      wait_n = 3;
      xfer(1'b0, 8'd200, 32'h0, 4'hF, rd, cyc, base);
      chk("R8 latency three waits", 32'(cyc), 32'd9);
      chk("R6 read of initial contents", rd, {iv(401), iv(400)});
      chk_pair("read high address", base, 8'd200, 1'b0, 2'b11, 2'b11);
   endtask

   initial begin : watchdog
      #(5.0 * 20000);
      if (!done) begin
         nchk++;
         nerr++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end

   initial begin : main
      t_reset();
      t_write_full();
      t_read_back();
      t_partial_lo();
      t_partial_hi();
      t_byte_mix();
      t_read_untouched();
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule